// File: doc/BRIEF.md
# Write-Protection and Status Unit for a Serial Memory

This unit holds the protection state of a small serial nonvolatile memory. It keeps the write-enable latch and three persistent status bits: a two-bit protected-zone code and a pin-lock enable. From these it builds the status byte that a serial front end shifts out. It also tells the front end whether a status write is allowed now, and whether the array address on its query port lies in the protected zone.

A status write arrives as a one-cycle request with a data byte while chip select is low. It is held in a staging register. The internal timed cycle starts when chip select rises, and the persistent bits change on the completion pulse of that cycle. If the protect pin goes low while chip select is still low and the lock enable is 1, the staged write is dropped. Once the cycle has started, the pin no longer affects it. Every completed write cycle, whether to the array or to the status bits, clears the write-enable latch.

Top module: `wp_status_unit`

## Requirements
- R1: After reset the write-enable latch, the zone code and the lock enable are all 0. With `busy` low the status byte reads 0x00 and `sr_writable` is 0.
- R2: A `wel_set` pulse sets the write-enable latch and a `wel_clr` pulse clears it. When both come in the same cycle, the clear wins. Both strobes are ignored while `busy` is 1. Neither depends on the protect pin.
- R3: When `busy` is 0 the status byte is built as follows: bit 0 is 0, bit 1 is the write-enable latch, bits 3:2 are the zone code, bits 6:4 are 0 and bit 7 is the lock enable. When `busy` is 1 the status byte is 0xFF.
- R4: For an array of DEPTH words, `addr_protected` depends on the zone code. Code 00 protects no address. Code 01 protects addresses at or above 3*DEPTH/4. Code 10 protects addresses at or above DEPTH/2. Code 11 protects every address. The pin lock does not change this output.
- R5: `sr_writable` is 1 exactly when the latch is set, `busy` is 0, and the hardware lock is off. The hardware lock is on when `wp_n` is 0 and the lock enable is 1.
- R6: A status write request is accepted only when `sr_writable` is 1 and `cs_n` is 0. A request that is not accepted leaves every bit unchanged. An accepted request takes bit 7 of the data as the lock enable and bits 3:2 as the zone code; the other data bits are ignored. The new values appear only after the first `cycle_done` pulse that follows the rise of `cs_n`.
- R7: While a write is staged and `cs_n` is still 0, `wp_n` at 0 with the lock enable at 1 drops the write. After `cs_n` has risen, `wp_n` has no effect on the write.
- R8: A `cycle_done` pulse clears the write-enable latch.
- R9: While `wp_n` is 0 and the lock enable is 1, the lock enable cannot be cleared by any write that was not already started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select from the serial side, active low |
| wel_set | input | 1 | Pulse: set the write-enable latch |
| wel_clr | input | 1 | Pulse: clear the write-enable latch |
| sr_wr_req | input | 1 | Pulse: status write request |
| sr_wr_data | input | 8 | Data byte of the status write |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | An internal write cycle is in progress |
| cycle_done | input | 1 | Pulse: an internal write cycle has completed |
| query_addr | input | $clog2(DEPTH) | Array address to classify |
| status_byte | output | 8 | Composed status byte |
| sr_writable | output | 1 | A status write would be accepted now |
| addr_protected | output | 1 | query_addr lies in the protected zone |

## Verification
The hardest case to reach is the race between the protect pin and chip select. The pin must fall in the single window after a status write has been staged but before chip select rises. A second run must lower the pin one cycle after chip select rises, while the staged write waits for its completion pulse. The bench drives these two orders on separate cycle boundaries and reads the persistent bits back through the status byte. The zone decoder is swept over every address of a 16-word configuration under all four codes.

// File: rtl/wp_status_pkg.sv
package wp_status_pkg;
  typedef enum logic [1:0] {
    STG_IDLE   = 2'd0,
    STG_ARMED  = 2'd1,
    STG_COMMIT = 2'd2
  } stage_e;

  typedef struct packed {
    logic       lock_en;
    logic [1:0] zone;
  } nv_bits_t;

  localparam int unsigned POS_LOCK = 7;
  localparam int unsigned POS_ZHI  = 3;
  localparam int unsigned POS_ZLO  = 2;
endpackage

// File: rtl/wel_latch.sv
module wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic busy_i,
  input  logic done_i,
  output logic wel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wel_o <= 1'b0;
    else if (done_i)     wel_o <= 1'b0;
    else if (!busy_i) begin
      if (clr_i)         wel_o <= 1'b0;
      else if (set_i)    wel_o <= 1'b1;
    end
  end

  assert_done_clears_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !wel_o);
  assert_busy_freezes_wel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !done_i) |=> $stable(wel_o));
endmodule

// File: rtl/nv_stage.sv
module nv_stage
  import wp_status_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_n,
  input  logic     req_i,
  input  nv_bits_t req_bits_i,
  input  logic     writable_i,
  input  logic     hw_lock_i,
  input  logic     done_i,
  output nv_bits_t nv_o
);
  stage_e   stage_q;
  nv_bits_t staged_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= STG_IDLE;
      staged_q <= '0;
      nv_o     <= '0;
    end else begin
      unique case (stage_q)
        STG_IDLE: begin
          if (req_i && writable_i && !cs_n) begin
            staged_q <= req_bits_i;
            stage_q  <= STG_ARMED;
          end
        end
        STG_ARMED: begin
          if (!cs_n && hw_lock_i) stage_q <= STG_IDLE;
          else if (cs_n)          stage_q <= STG_COMMIT;
        end
        STG_COMMIT: begin
          if (done_i) begin
            nv_o    <= staged_q;
            stage_q <= STG_IDLE;
          end
        end
        default: stage_q <= STG_IDLE;
      endcase
    end
  end

  assert_nv_only_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_i && stage_q == STG_COMMIT) |=> $stable(nv_o));
  assert_pin_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == STG_ARMED && !cs_n && hw_lock_i) |=> stage_q == STG_IDLE);
  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_lock_i && stage_q != STG_COMMIT) |=> nv_o.lock_en);
endmodule

// File: rtl/zone_check.sv
module zone_check #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic [1:0]    zone_i,
  input  logic [AW-1:0] addr_i,
  output logic          prot_o
);
  localparam logic [AW:0] BOUND_QTR  = (AW+1)'(DEPTH - DEPTH/4);
  localparam logic [AW:0] BOUND_HALF = (AW+1)'(DEPTH/2);

  logic [AW:0] addr_ext;
  assign addr_ext = {1'b0, addr_i};

  always_comb begin
    unique case (zone_i)
      2'b00:   prot_o = 1'b0;
      2'b01:   prot_o = (addr_ext >= BOUND_QTR);
      2'b10:   prot_o = (addr_ext >= BOUND_HALF);
      default: prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit
  import wp_status_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wel_set,
  input  logic          wel_clr,
  input  logic          sr_wr_req,
  input  logic [7:0]    sr_wr_data,
  input  logic          wp_n,
  input  logic          busy,
  input  logic          cycle_done,
  input  logic [AW-1:0] query_addr,
  output logic [7:0]    status_byte,
  output logic          sr_writable,
  output logic          addr_protected
);
  logic     wel;
  logic     hw_lock;
  nv_bits_t nv;
  nv_bits_t req_bits;
  logic     unused_data_bits;

  assign unused_data_bits = ^{sr_wr_data[6:4], sr_wr_data[1:0]};
  assign req_bits = '{lock_en: sr_wr_data[POS_LOCK],
                      zone:    sr_wr_data[POS_ZHI:POS_ZLO]};

  assign hw_lock     = !wp_n && nv.lock_en;
  assign sr_writable = wel && !busy && !hw_lock;

  wel_latch u_wel (
    .clk(clk), .rst_n(rst_n), .set_i(wel_set), .clr_i(wel_clr),
    .busy_i(busy), .done_i(cycle_done), .wel_o(wel)
  );

  nv_stage u_nv (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .req_i(sr_wr_req),
    .req_bits_i(req_bits), .writable_i(sr_writable), .hw_lock_i(hw_lock),
    .done_i(cycle_done), .nv_o(nv)
  );

  zone_check #(.DEPTH(DEPTH)) u_zone (
    .zone_i(nv.zone), .addr_i(query_addr), .prot_o(addr_protected)
  );

  always_comb begin
    if (busy) status_byte = 8'hFF;
    else      status_byte = {nv.lock_en, 3'b000, nv.zone, wel, 1'b0};
  end

  assert_open_zone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[3:2] == 2'b00 && !busy) |-> !addr_protected);
  assert_whole_zone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[3:2] == 2'b11 && !busy) |-> addr_protected);
  assert_locked_not_writable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && status_byte[7]) |-> !sr_writable);
endmodule

// File: tb/test_wp_status_unit.sv
module test_wp_status_unit;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wel_set = 1'b0, wel_clr = 1'b0, sr_wr_req = 1'b0;
  logic [7:0] sr_wr_data = 8'h00;
  logic wp_n = 1'b1, busy = 1'b0, cycle_done = 1'b0;
  logic [AW-1:0] query_addr = '0;
  logic [7:0] status_byte;
  logic sr_writable, addr_protected;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wp_status_unit #(.DEPTH(DEPTH)) i_wp_status_unit (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wel_set(wel_set), .wel_clr(wel_clr),
    .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data), .wp_n(wp_n), .busy(busy),
    .cycle_done(cycle_done), .query_addr(query_addr), .status_byte(status_byte),
    .sr_writable(sr_writable), .addr_protected(addr_protected)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic pulse_set();
    wel_set = 1'b1; tick(); wel_set = 1'b0;
  endtask

  task automatic status_write(input logic [7:0] d);
    cs_n = 1'b0; sr_wr_req = 1'b1; sr_wr_data = d; tick();
    sr_wr_req = 1'b0; cs_n = 1'b1; tick();
    cycle_done = 1'b1; tick(); cycle_done = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1; tick();
    query_addr = AW'(DEPTH - 1); #1;
    check("R1 status after reset", status_byte, 8'h00);
    check("R1 writable after reset", {7'b0, sr_writable}, 8'h00);
    check("R1 no zone after reset", {7'b0, addr_protected}, 8'h00);

    pulse_set();
    check("R2 set latch", status_byte, 8'h02);
    check("R5 writable with latch", {7'b0, sr_writable}, 8'h01);
    busy = 1'b1; #1;
    check("R3 busy reads all ones", status_byte, 8'hFF);
    check("R5 not writable while busy", {7'b0, sr_writable}, 8'h00);
    wel_clr = 1'b1; tick(); wel_clr = 1'b0; busy = 1'b0; #1;
    check("R2 clear ignored while busy", status_byte, 8'h02);
    wp_n = 1'b0; wel_clr = 1'b1; wel_set = 1'b1; tick();
    wel_clr = 1'b0; wel_set = 1'b0; wp_n = 1'b1;
    check("R2 clear wins and ignores pin", status_byte, 8'h00);
    pulse_set();
    cycle_done = 1'b1; tick(); cycle_done = 1'b0;
    check("R8 done clears latch", status_byte, 8'h00);

    status_write(8'h8C);
    check("R6 write without latch ignored", status_byte, 8'h00);

    pulse_set();
    cs_n = 1'b0; sr_wr_req = 1'b1; sr_wr_data = 8'h74; tick();
    sr_wr_req = 1'b0; cs_n = 1'b1; tick(); tick();
    check("R6 not applied before done", status_byte, 8'h02);
    cycle_done = 1'b1; tick(); cycle_done = 1'b0;
    check("R6 R3 applied, other bits ignored", status_byte, 8'h04);

    for (int c = 0; c < 4; c++) begin
      pulse_set();
      status_write(8'(c << 2));
      check("R3 zone code in status", status_byte, 8'(c << 2));
      for (int a = 0; a < DEPTH; a++) begin
        logic exp;
        query_addr = AW'(a); #1;
        case (c)
          0: exp = 1'b0;
          1: exp = (a >= DEPTH - DEPTH / 4);
          2: exp = (a >= DEPTH / 2);
          default: exp = 1'b1;
        endcase
        check($sformatf("R4 code %0d addr %0d", c, a), {7'b0, addr_protected}, {7'b0, exp});
      end
    end

    pulse_set();
    status_write(8'h80);
    check("R6 lock enable written", status_byte, 8'h80);
    wp_n = 1'b0;
    pulse_set();
    check("R2 set under pin lock", status_byte, 8'h82);
    check("R5 locked not writable", {7'b0, sr_writable}, 8'h00);
    status_write(8'h00);
    check("R9 lock enable kept while pin low", status_byte, 8'h80);
    wp_n = 1'b1;
    pulse_set();
    check("R5 writable after pin high", {7'b0, sr_writable}, 8'h01);

    cs_n = 1'b0; sr_wr_req = 1'b1; sr_wr_data = 8'h00; tick();
    sr_wr_req = 1'b0; wp_n = 1'b0; tick();
    cs_n = 1'b1; wp_n = 1'b1; tick();
    cycle_done = 1'b1; tick(); cycle_done = 1'b0;
    check("R7 pin low with cs low aborts", status_byte, 8'h80);

    pulse_set();
    cs_n = 1'b0; sr_wr_req = 1'b1; sr_wr_data = 8'h00; tick();
    sr_wr_req = 1'b0; cs_n = 1'b1; tick();
    wp_n = 1'b0; tick();
    cycle_done = 1'b1; tick(); cycle_done = 1'b0; wp_n = 1'b1;
    check("R7 pin after start has no effect", status_byte, 8'h00);

    pulse_set();
    status_write(8'h84);
    wp_n = 1'b0;
    query_addr = '0; #1;
    check("R4 low address open under lock", {7'b0, addr_protected}, 8'h00);
    query_addr = AW'(DEPTH - 1); #1;
    check("R4 top address guarded under lock", {7'b0, addr_protected}, 8'h01);
    wp_n = 1'b1;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule